// File: doc/BRIEF.md
# Stereo Audio Serial Transmitter

This block takes a parallel stereo sample pair and sends it out one bit at a time on a single data line. Two clocks frame the data. A bit clock marks each bit. A framing clock has a level that shows which channel is on the line. Three framings are supported: left-justified, right-justified and I2S. The word length can be 16, 20 or 24 bits. The block always takes 24-bit samples and sends their upper bits.

In master mode the block divides its system clock to make the bit clock and the framing clock. The bit clock runs at 64 times the sample rate, and the system clock may be 128, 192, 256, 384, 512 or 768 times the sample rate. In slave mode both clocks come in from outside. The block samples them in its system clock domain, so the system clock must run several times faster than the incoming bit clock. Sample pairs enter through a valid/ready handshake. The handshake is offered once per frame, in the system clock cycle that starts the left channel.

Top module: `aud_ser_tx`

## Requirements
- R1: While reset is asserted, `sdata`, `bclk_out`, `lrclk_out`, `s_ready` and `underrun` are all 0.
- R2: In master mode, `cfg_ratio` selects the bit-clock period in system clock cycles: 0 gives 2, 1 gives 3, 2 gives 4, 3 gives 6, 4 gives 8, 5 gives 12, and 6 or 7 give 4. Each framing-clock level lasts exactly 32 bit-clock periods.
- R3: In master mode, `sdata` and `lrclk_out` change only in the system clock cycle where `bclk_out` goes from 1 to 0.
- R4: With `cfg_fmt` = 01 (left-justified), the left channel is sent while the framing clock is high. The MSB is sent in the first bit period after the framing-clock edge.
- R5: With `cfg_fmt` = 10 (I2S, and 11 behaves the same), the left channel is sent while the framing clock is low. The MSB is sent in the second bit period after the framing-clock edge.
- R6: With `cfg_fmt` = 00 (right-justified), the left channel is sent while the framing clock is high. The LSB is sent in the last bit period before the next framing-clock edge.
- R7: `cfg_wlen` = 00 selects 16 bits, 01 selects 20 bits, and 10 or 11 select 24 bits. The bits sent are the top bits of the 24-bit input, MSB first. Every bit period not filled by the word carries 0.
- R8: `s_ready` is a one-cycle pulse in the cycle that starts a left channel. If `s_valid` is high in that cycle, `s_left` and `s_right` are captured and sent in that frame. Every accepted pair is sent, in the order it was accepted.
- R9: If `s_valid` is low when `s_ready` pulses, the previously captured pair is sent again and `underrun` goes to 1. `underrun` then stays 1 until reset.
- R10: With `cfg_master` = 0, the frame follows the external `bclk_in` and `lrclk_in`, using the same framing rules as master mode. While the block is in slave mode, `bclk_out` and `lrclk_out` are held at 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_master | input | 1 | 1 = generate the clocks, 0 = follow external clocks |
| cfg_fmt | input | 2 | Framing: 00 right-justified, 01 left-justified, 10/11 I2S |
| cfg_wlen | input | 2 | Word length: 00 16 bits, 01 20 bits, 10/11 24 bits |
| cfg_ratio | input | 3 | System-clock to sample-rate ratio code (master mode) |
| bclk_in | input | 1 | External bit clock (slave mode) |
| lrclk_in | input | 1 | External framing clock (slave mode) |
| s_valid | input | 1 | A sample pair is offered |
| s_ready | output | 1 | Pair is taken in this cycle if valid |
| s_left | input | 24 | Left sample |
| s_right | input | 24 | Right sample |
| bclk_out | output | 1 | Generated bit clock, 0 in slave mode |
| lrclk_out | output | 1 | Generated framing clock, 0 in slave mode |
| sdata | output | 1 | Serial data |
| underrun | output | 1 | Sticky: a frame started with no new pair |

## Verification
The assertions check the following on every cycle: data and framing-clock changes happen only on a falling bit-clock edge, `s_ready` is a single-cycle pulse that comes just before a falling edge, the underrun flag is set and then stays set, and the output clocks stay quiet in slave mode. Only the bench scenarios can show where each bit of the word lands in each framing, that truncation and zero padding are correct, the divider period for each ratio, and that pairs come out complete and in order. The bench shows this by rebuilding each 32-bit channel from the pins and comparing it with an image computed from the accepted pair.

// File: rtl/aud_tx_pkg.sv
package aud_tx_pkg;

  localparam int unsigned SMP_W  = 24;
  localparam int unsigned SLOT_N = 32;
  localparam int unsigned POS_W  = $clog2(SLOT_N);
  localparam int unsigned FRM_W  = POS_W + 1;
  localparam int unsigned DIV_W  = 4;

  typedef enum logic [1:0] {
    FMT_RJ  = 2'b00,
    FMT_LJ  = 2'b01,
    FMT_I2S = 2'b10,
    FMT_ALT = 2'b11
  } fmt_e;

  // 10 and 11 both select I2S framing
  function automatic logic fmt_is_i2s(input logic [1:0] f);
    return f[1];
  endfunction

  // number of data bits per channel for a word-length code
  function automatic logic [POS_W:0] word_bits(input logic [1:0] c);
    case (c)
      2'b00:   return 6'd16;
      2'b01:   return 6'd20;
      default: return 6'd24;
    endcase
  endfunction

  // system clocks per bit clock: ratio / 64
  function automatic logic [DIV_W-1:0] ratio_div(input logic [2:0] r);
    case (r)
      3'd0:    return 4'd2;
      3'd1:    return 4'd3;
      3'd2:    return 4'd4;
      3'd3:    return 4'd6;
      3'd4:    return 4'd8;
      3'd5:    return 4'd12;
      default: return 4'd4;
    endcase
  endfunction

endpackage

// File: rtl/aud_bclk_div.sv
module aud_bclk_div
  import aud_tx_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       en,
  input  logic [2:0] ratio,
  output logic       tick,
  output logic       bclk
);

  logic [DIV_W-1:0] cnt_q, cnt_n;
  logic [DIV_W-1:0] div;
  logic [DIV_W-1:0] half;
  logic             bclk_q, bclk_n;

  always_comb begin
    div  = ratio_div(ratio);
    half = div >> 1;
    // falling bit-clock edge happens on the clock that wraps the counter
    tick = en && (cnt_q >= div - 1'b1);
    if (!en)       cnt_n = '0;
    else if (tick) cnt_n = '0;
    else           cnt_n = cnt_q + 1'b1;
    // low for the first half period (floor), high for the rest
    bclk_n = en && (cnt_n >= half);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q  <= '0;
      bclk_q <= 1'b0;
    end else begin
      cnt_q  <= cnt_n;
      bclk_q <= bclk_n;
    end
  end

  assign bclk = bclk_q;

endmodule

// File: rtl/aud_slave_in.sv
module aud_slave_in #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic bclk_in,
  input  logic lrclk_in,
  output logic tick,
  output logic lr_lvl
);

  logic [STAGES-1:0] b_sync_q;
  logic [STAGES-1:0] l_sync_q;
  logic              b_last_q;

  for (genvar g = 0; g < STAGES; g++) begin : g_sync
    if (g == 0) begin : g_first
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          b_sync_q[g] <= 1'b0;
          l_sync_q[g] <= 1'b0;
        end else begin
          b_sync_q[g] <= bclk_in;
          l_sync_q[g] <= lrclk_in;
        end
      end
    end else begin : g_rest
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          b_sync_q[g] <= 1'b0;
          l_sync_q[g] <= 1'b0;
        end else begin
          b_sync_q[g] <= b_sync_q[g-1];
          l_sync_q[g] <= l_sync_q[g-1];
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) b_last_q <= 1'b0;
    else        b_last_q <= b_sync_q[STAGES-1];
  end

  assign tick   = b_last_q && !b_sync_q[STAGES-1];
  assign lr_lvl = l_sync_q[STAGES-1];

endmodule

// File: rtl/aud_frame_seq.sv
module aud_frame_seq
  import aud_tx_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             master,
  input  logic [1:0]       fmt,
  input  logic             m_tick,
  input  logic             s_tick,
  input  logic             s_lr,
  output logic             tick,
  output logic [POS_W-1:0] pos_n,
  output logic             left_n,
  output logic             start_left,
  output logic             lrclk
);

  logic [FRM_W-1:0] slot_q, slot_n;
  logic [POS_W-1:0] spos_q, spos_n;
  logic             slr_q;
  logic             lr_q, lr_n;
  logic             i2s;
  logic             s_edge;

  always_comb begin
    i2s    = fmt_is_i2s(fmt);
    slot_n = slot_q + 1'b1;
    s_edge = (s_lr != slr_q);
    if (s_edge)            spos_n = '0;
    else if (&spos_q)      spos_n = spos_q;
    else                   spos_n = spos_q + 1'b1;

    if (master) begin
      tick       = m_tick;
      pos_n      = slot_n[POS_W-1:0];
      left_n     = !slot_n[FRM_W-1];
      start_left = (slot_n == '0);
    end else begin
      tick       = s_tick;
      pos_n      = spos_n;
      left_n     = i2s ? !s_lr : s_lr;
      start_left = s_edge && (i2s ? !s_lr : s_lr);
    end
    // left is high for LJ/RJ, low for I2S
    lr_n = left_n ^ i2s;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      slot_q <= '1;
      spos_q <= '1;
      slr_q  <= 1'b0;
      lr_q   <= 1'b0;
    end else begin
      if (master && m_tick) slot_q <= slot_n;
      if (!master && s_tick) begin
        spos_q <= spos_n;
        slr_q  <= s_lr;
      end
      if (!master)     lr_q <= 1'b0;
      else if (m_tick) lr_q <= lr_n;
    end
  end

  assign lrclk = lr_q;

endmodule

// File: rtl/aud_word_ser.sv
module aud_word_ser
  import aud_tx_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick,
  input  logic [POS_W-1:0] pos_n,
  input  logic             left_n,
  input  logic             start_left,
  input  logic [1:0]       fmt,
  input  logic [1:0]       wlen,
  input  logic             s_valid,
  output logic             s_ready,
  input  logic [SMP_W-1:0] s_left,
  input  logic [SMP_W-1:0] s_right,
  output logic             sdata,
  output logic             underrun
);

  localparam logic [POS_W:0] SLOT_V = SLOT_N[POS_W:0];

  logic [SMP_W-1:0] lat_l_q, lat_r_q;
  logic [SMP_W-1:0] cur_l, cur_r, word, shifted;
  logic [POS_W:0]   wb, p6, off, k;
  logic             take, vld, bit_n;
  logic             sd_q, sd_n, und_q, und_n;

  always_comb begin
    s_ready = tick && start_left;
    take    = s_ready && s_valid;
    cur_l   = take ? s_left  : lat_l_q;
    cur_r   = take ? s_right : lat_r_q;
    word    = left_n ? cur_l : cur_r;

    wb  = word_bits(wlen);
    p6  = {1'b0, pos_n};
    off = SLOT_V - wb;
    case (fmt)
      FMT_RJ: begin
        vld = (p6 >= off);
        k   = p6 - off;
      end
      FMT_LJ: begin
        vld = (p6 < wb);
        k   = p6;
      end
      default: begin
        vld = (p6 != '0) && (p6 <= wb);
        k   = p6 - 1'b1;
      end
    endcase
    shifted = word << k;
    bit_n   = vld && shifted[SMP_W-1];

    sd_n  = tick ? bit_n : sd_q;
    und_n = und_q || (s_ready && !s_valid);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lat_l_q <= '0;
      lat_r_q <= '0;
      sd_q    <= 1'b0;
      und_q   <= 1'b0;
    end else begin
      if (take) begin
        lat_l_q <= s_left;
        lat_r_q <= s_right;
      end
      sd_q  <= sd_n;
      und_q <= und_n;
    end
  end

  assign sdata    = sd_q;
  assign underrun = und_q;

endmodule

// File: rtl/aud_ser_tx.sv
module aud_ser_tx
  import aud_tx_pkg::*;
#(
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cfg_master,
  input  logic [1:0]       cfg_fmt,
  input  logic [1:0]       cfg_wlen,
  input  logic [2:0]       cfg_ratio,
  input  logic             bclk_in,
  input  logic             lrclk_in,
  input  logic             s_valid,
  output logic             s_ready,
  input  logic [SMP_W-1:0] s_left,
  input  logic [SMP_W-1:0] s_right,
  output logic             bclk_out,
  output logic             lrclk_out,
  output logic             sdata,
  output logic             underrun
);

  logic             m_tick, s_tick, s_lr;
  logic             tick, left_n, start_left;
  logic [POS_W-1:0] pos_n;

  aud_bclk_div i_div (
    .clk   (clk),
    .rst_n (rst_n),
    .en    (cfg_master),
    .ratio (cfg_ratio),
    .tick  (m_tick),
    .bclk  (bclk_out)
  );

  aud_slave_in #(.STAGES(SYNC_STAGES)) i_sin (
    .clk      (clk),
    .rst_n    (rst_n),
    .bclk_in  (bclk_in),
    .lrclk_in (lrclk_in),
    .tick     (s_tick),
    .lr_lvl   (s_lr)
  );

  aud_frame_seq i_seq (
    .clk        (clk),
    .rst_n      (rst_n),
    .master     (cfg_master),
    .fmt        (cfg_fmt),
    .m_tick     (m_tick),
    .s_tick     (s_tick),
    .s_lr       (s_lr),
    .tick       (tick),
    .pos_n      (pos_n),
    .left_n     (left_n),
    .start_left (start_left),
    .lrclk      (lrclk_out)
  );

  aud_word_ser i_ser (
    .clk        (clk),
    .rst_n      (rst_n),
    .tick       (tick),
    .pos_n      (pos_n),
    .left_n     (left_n),
    .start_left (start_left),
    .fmt        (cfg_fmt),
    .wlen       (cfg_wlen),
    .s_valid    (s_valid),
    .s_ready    (s_ready),
    .s_left     (s_left),
    .s_right    (s_right),
    .sdata      (sdata),
    .underrun   (underrun)
  );

endmodule

// File: rtl/aud_ser_tx_chk.sv
module aud_ser_tx_chk (
  input logic clk,
  input logic rst_n,
  input logic cfg_master,
  input logic s_valid,
  input logic s_ready,
  input logic bclk_out,
  input logic lrclk_out,
  input logic sdata,
  input logic underrun
);

  // R3: data moves only with a falling generated bit clock
  p_data_on_fall_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_master && $stable(cfg_master) && !$stable(sdata)) |-> $fell(bclk_out));

  // R3: framing clock moves only with a falling generated bit clock
  p_lr_on_fall_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_master && $stable(cfg_master) && !$stable(lrclk_out)) |-> $fell(bclk_out));

  // R8: ready is a single-cycle pulse
  p_ready_pulse_r8: assert property (@(posedge clk) disable iff (!rst_n)
    s_ready |=> !s_ready);

  // R8: in master mode the handshake precedes a falling bit-clock edge
  p_ready_at_fall_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (s_ready && cfg_master) |=> $fell(bclk_out));

  // R9: missing sample at frame start raises the flag
  p_underrun_set_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (s_ready && !s_valid) |=> underrun);

  // R9: the flag is sticky
  p_underrun_sticky_r9: assert property (@(posedge clk) disable iff (!rst_n)
    underrun |=> underrun);

  // R10: output clocks quiet in slave mode
  p_slave_quiet_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (!cfg_master && !$past(cfg_master)) |-> (!bclk_out && !lrclk_out));

endmodule

bind aud_ser_tx aud_ser_tx_chk i_chk (.*);

// File: tb/test_aud_ser_tx.sv
module test_aud_ser_tx;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        cfg_master;
  logic [1:0]  cfg_fmt, cfg_wlen;
  logic [2:0]  cfg_ratio;
  logic        bclk_in, lrclk_in;
  logic        s_valid, s_ready;
  logic [23:0] s_left, s_right;
  logic        bclk_out, lrclk_out, sdata, underrun;

  always #5 clk = ~clk;

  aud_ser_tx i_aud_ser_tx (
    .clk(clk), .rst_n(rst_n), .cfg_master(cfg_master), .cfg_fmt(cfg_fmt),
    .cfg_wlen(cfg_wlen), .cfg_ratio(cfg_ratio), .bclk_in(bclk_in),
    .lrclk_in(lrclk_in), .s_valid(s_valid), .s_ready(s_ready),
    .s_left(s_left), .s_right(s_right), .bclk_out(bclk_out),
    .lrclk_out(lrclk_out), .sdata(sdata), .underrun(underrun)
  );

  typedef struct { logic [23:0] l; logic [23:0] r; } pair_t;
  pair_t exp_q[$];
  pair_t last_p;

  int errs = 0;
  int checks = 0;
  bit done = 0;

  task automatic chk(input bit ok, input string req, input string what,
                     input longint act, input longint expv);
    checks++;
    if (!ok) begin
      errs++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, expv);
    end
  endtask

  // expected 32-slot channel image, first slot in bit 31
  function automatic logic [31:0] img(input logic [23:0] w, input logic [1:0] f,
                                      input logic [1:0] wl);
    int wb;
    logic [31:0] m;
    wb = (wl == 2'b00) ? 16 : (wl == 2'b01) ? 20 : 24;
    m = '0;
    for (int p = 0; p < 32; p++) begin
      int k;
      if (f == 2'b01)      k = p;           // R4 left-justified
      else if (f == 2'b00) k = p - (32 - wb); // R6 right-justified
      else                 k = p - 1;       // R5 I2S
      if (k >= 0 && k < wb) m[31-p] = w[23-k]; // R7 top bits, rest 0
    end
    return m;
  endfunction

  function automatic pair_t mk(input int i);
    pair_t p;
    p.l = 24'hA5C3F1 ^ (24'h13579B * i[23:0]);
    p.r = 24'h5E0F3C ^ (24'h2468AD * i[23:0]);
    return p;
  endfunction

  // ---------------- slave clock generator (8 clk per bit) ----------------
  int gc, gb;
  always @(negedge clk) begin
    if (!rst_n || cfg_master) begin
      gc = 0; gb = 40;
      bclk_in  <= 1'b1;
      lrclk_in <= cfg_fmt[1] ? 1'b1 : 1'b0;
    end else begin
      gc = (gc + 1) % 8;
      if (gc == 0) begin
        gb = (gb + 1) % 64;
        bclk_in  <= 1'b0;
        lrclk_in <= (gb < 32) ? !cfg_fmt[1] : cfg_fmt[1];
      end else if (gc == 4) begin
        bclk_in <= 1'b1;
      end
    end
  end

  // ---------------- monitor / scoreboard ----------------
  logic mb_prev, m_lr, have_lr, have_left, bv, lv;
  logic [31:0] mbuf, left_img;
  int mcnt, last_cnt, bper, last_fall, cyc, r3_viol;
  logic sd_prev, lro_prev, bo_prev;

  task automatic finalize();
    bit is_left;
    pair_t e;
    is_left = cfg_fmt[1] ? !m_lr : m_lr;
    if (mcnt == 32) begin
      last_cnt = mcnt;
      if (is_left) begin
        left_img = mbuf; have_left = 1;
      end else if (have_left && exp_q.size() != 0) begin
        e = exp_q.pop_front();
        chk(left_img == img(e.l, cfg_fmt, cfg_wlen), "R8", "left channel image",
            left_img, img(e.l, cfg_fmt, cfg_wlen));
        chk(mbuf == img(e.r, cfg_fmt, cfg_wlen), "R8", "right channel image",
            mbuf, img(e.r, cfg_fmt, cfg_wlen));
        have_left = 0;
      end
    end else if (is_left && exp_q.size() != 0) begin
      e = exp_q.pop_front(); // partial first frame after reset is not compared
    end
  endtask

  initial begin
    cyc = 0; r3_viol = 0; bper = 0; last_cnt = 0; last_fall = 0;
  end

  always @(negedge clk) begin
    cyc++;
    if (!rst_n) begin
      mb_prev = 0; have_lr = 0; have_left = 0; mcnt = 0;
      sd_prev = 0; lro_prev = 0; bo_prev = 0;
    end else begin
      if (cfg_master) begin
        if ((sdata != sd_prev || lrclk_out != lro_prev) && !(bo_prev && !bclk_out))
          r3_viol++;
        if (bo_prev && !bclk_out) begin
          bper = cyc - last_fall; last_fall = cyc;
        end
      end
      sd_prev = sdata; lro_prev = lrclk_out; bo_prev = bclk_out;
      bv = cfg_master ? bclk_out  : bclk_in;
      lv = cfg_master ? lrclk_out : lrclk_in;
      if (bv && !mb_prev) begin
        if (!have_lr) begin
          have_lr = 1; m_lr = lv; mcnt = 99; mbuf = '0;
        end else if (lv != m_lr) begin
          finalize();
          mbuf = '0; mcnt = 0; m_lr = lv;
        end
        mbuf = {mbuf[30:0], sdata};
        mcnt++;
      end
      mb_prev = bv;
    end
  end

  // ---------------- driver ----------------
  task automatic do_reset(input logic m, input logic [1:0] f, input logic [1:0] wl,
                          input logic [2:0] ra);
    @(negedge clk);
    rst_n = 0; s_valid = 0;
    cfg_master = m; cfg_fmt = f; cfg_wlen = wl; cfg_ratio = ra;
    exp_q.delete();
    repeat (3) @(negedge clk);
    chk(!sdata && !bclk_out && !lrclk_out && !s_ready && !underrun, "R1",
        "outputs in reset", {sdata, bclk_out, lrclk_out, s_ready, underrun}, 0);
    rst_n = 1;
  endtask

  task automatic send_pair(input pair_t p);
    s_left = p.l; s_right = p.r; s_valid = 1;
    while (!s_ready) @(negedge clk);
    exp_q.push_back(p);
    last_p = p;
    @(negedge clk);
    s_valid = 0;
  endtask

  task automatic skip_pair();
    s_valid = 0;
    while (!s_ready) @(negedge clk);
    exp_q.push_back(last_p);   // R9: previous pair repeats
    @(negedge clk);
  endtask

  task automatic drain();
    int t = 0;
    while (exp_q.size() != 0 && t < 20000) begin
      @(negedge clk); t++;
    end
    chk(exp_q.size() == 0, "R8", "pairs left unsent", exp_q.size(), 0);
  endtask

  initial begin
    rst_n = 0; s_valid = 0; s_left = '0; s_right = '0;
    cfg_master = 1; cfg_fmt = 2'b01; cfg_wlen = 2'b10; cfg_ratio = 3'd2;

    // Test A: master, left-justified (R4), 24 bits, ratio 256
    do_reset(1, 2'b01, 2'b10, 3'd2);
    for (int i = 0; i < 4; i++) send_pair(mk(i));
    chk(underrun == 0, "R9", "no underrun with steady supply", underrun, 0);
    drain();
    chk(bper == 4, "R2", "bit period ratio 256", bper, 4);
    chk(last_cnt == 32, "R2", "bits per channel", last_cnt, 32);
    chk(r3_viol == 0, "R3", "changes off falling edge", r3_viol, 0);

    // Test B: master, I2S (R5), 16 bits (R7), ratio 192
    do_reset(1, 2'b10, 2'b00, 3'd1);
    for (int i = 4; i < 8; i++) send_pair(mk(i));
    drain();
    chk(bper == 3, "R2", "bit period ratio 192", bper, 3);
    chk(r3_viol == 0, "R3", "changes off falling edge", r3_viol, 0);

    // Test C: master, right-justified (R6), 20 bits (R7), ratio 768
    do_reset(1, 2'b00, 2'b01, 3'd5);
    for (int i = 8; i < 11; i++) send_pair(mk(i));
    drain();
    chk(bper == 12, "R2", "bit period ratio 768", bper, 12);
    chk(r3_viol == 0, "R3", "changes off falling edge", r3_viol, 0);

    // Test D: underrun (R9), left-justified 16 bits, ratio 128
    do_reset(1, 2'b01, 2'b00, 3'd0);
    send_pair(mk(11));
    send_pair(mk(12));
    chk(underrun == 0, "R9", "flag before gap", underrun, 0);
    skip_pair();
    chk(underrun == 1, "R9", "flag after gap", underrun, 1);
    send_pair(mk(13));
    drain();
    chk(underrun == 1, "R9", "flag sticky", underrun, 1);
    chk(bper == 2, "R2", "bit period ratio 128", bper, 2);

    // Test E: slave, I2S 24 bits (R10)
    do_reset(0, 2'b10, 2'b10, 3'd2);
    for (int i = 14; i < 17; i++) begin
      send_pair(mk(i));
      chk(!bclk_out && !lrclk_out, "R10", "output clocks in slave",
          {bclk_out, lrclk_out}, 0);
    end
    drain();

    // Test F: slave, right-justified 20 bits (R10, R6)
    do_reset(0, 2'b00, 2'b01, 3'd2);
    for (int i = 17; i < 19; i++) send_pair(mk(i));
    drain();

    done = 1;
    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errs++; checks++;
      $display("FAIL R8 watchdog expired actual=%0d expected=%0d", 200000, 0);
      $display("Result: errors=%0d of %0d checks", errs, checks);
      $finish;
    end
  end

endmodule